// File: doc/BRIEF.md
# Accumulator Output Scaler, Rounder and Saturator

This block turns a wide signed multiply-accumulate value into the form a signal-processing datapath writes out. The accumulator first passes through a shift stage with four settings. Each left-shift setting, and the no-shift setting, first checks the accumulator's head bits for overflow. The shifted value is then rounded to a chosen word length, with round-half-up on the bits that are dropped. The rounded value gets a second overflow check against the accumulator's usable range. When saturation is on and either check fails, the output is clamped to the positive or the negative limit.

The result path is purely combinational and is sign-extended to the output width. A single registered sticky flag records that an overflow was seen on any evaluated cycle. The owner of the datapath pulses a strobe on the cycles whose result it actually uses, and it pulses a sync input once per sample period to clear the flag.

Top module: `acc_out_scaler`

## Requirements
- R1: With shift select 0, the value passes unshifted, and overflow is detected unless accumulator bits 51:47 are all equal.
- R2: With shift select 1, overflow is detected unless accumulator bits 51:45 are all equal, and the value is shifted left by 2.
- R3: With shift select 2, overflow is detected unless accumulator bits 51:43 are all equal, and the value is shifted left by 4.
- R4: With shift select 3, the value is shifted right arithmetically by 8, and no overflow check is made before the shift.
- R5: Round select values 0, 5, 6 and 7 leave the shifted value unchanged.
- R6: Round select 1 adds 2^15 and zeroes bits 15:0. Select 2 adds 2^23 and zeroes bits 23:0. Select 3 adds 2^17 and zeroes bits 17:0. Select 4 adds 2^31 and zeroes bits 31:0.
- R7: After rounding, overflow is detected again unless bits 51:47 of the rounded value are all equal.
- R8: When saturation enable is 1 and overflow was detected, the result is 0xFFFF_8000_0000_0000 if bit 51 of the rounded value is 1, and 0x0000_7FFF_FFFF_FFFF otherwise. With saturation enable at 0, the unclamped rounded value is output even on overflow.
- R9: The overflow flag is set one clock after a cycle in which the evaluate strobe is high and overflow is detected. It keeps its value when the strobe is low, whatever the data inputs are.
- R10: The sync pulse clears the flag one clock later, and it takes priority over an evaluated overflow in the same cycle.
- R11: After synchronous reset, the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_in | input | 52 | Signed accumulator value |
| shift_sel | input | 2 | Shift setting: 0 none, 1 left 2, 2 left 4, 3 right 8 |
| round_sel | input | 3 | Rounding setting: 1 to 32, 2 to 24, 3 to 30, 4 to 16 bits; others none |
| sat_en | input | 1 | Clamp the result on overflow |
| eval_stb | input | 1 | The current result is consumed; update the flag |
| sync_pulse | input | 1 | Sample-period sync; clears the flag |
| result | output | 64 | Scaled, rounded, possibly clamped value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench feeds values that sit exactly on each guard boundary. A guard slice one bit too narrow or too wide would flag the largest legal value, or miss the smallest illegal one. It drives a value that passes the pre-shift check but carries into bit 47 through rounding. A design without the second check would neither flag nor clamp it. It uses a positive accumulator whose bit 51 goes clear after a left shift, and negative values that round toward zero. These catch a clamp keyed on the wrong bit and a rounding constant off by one position. The sticky tests check that un-strobed overflows are ignored, that a clean evaluation does not clear the flag, and that sync beats a same-cycle overflow.

// File: rtl/acc_scale_pkg.sv
package acc_scale_pkg;

  typedef enum logic [1:0] {
    SHIFT_KEEP = 2'd0,
    SHIFT_UP2  = 2'd1,
    SHIFT_UP4  = 2'd2,
    SHIFT_DN8  = 2'd3
  } shift_mode_e;

  typedef enum logic [2:0] {
    RND_OFF = 3'd0,
    RND_W32 = 3'd1,
    RND_W24 = 3'd2,
    RND_W30 = 3'd3,
    RND_W16 = 3'd4
  } round_mode_e;

endpackage

// File: rtl/acc_prescale.sv
module acc_prescale
  import acc_scale_pkg::*;
#(
  parameter int ACC_W  = 52,
  parameter int OUT_W  = 64,
  parameter int HEAD_W = 5,
  parameter int SH_A   = 2,
  parameter int SH_B   = 4,
  parameter int SH_R   = 8
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [1:0]       shift_sel,
  output logic [OUT_W-1:0] shifted,
  output logic             pre_ovf
);

  localparam int EXT_W = OUT_W - ACC_W;

  logic [OUT_W-1:0] ext;
  logic [2:0]       guard_ok;

  assign ext = {{EXT_W{acc[ACC_W-1]}}, acc};

  // one head-bit uniformity test per left-shift setting (including none)
  for (genvar g = 0; g < 3; g++) begin : g_guard
    localparam int GW = HEAD_W + ((g == 0) ? 0 : (g == 1) ? SH_A : SH_B);
    logic [GW-1:0] head;
    assign head        = acc[ACC_W-1 -: GW];
    assign guard_ok[g] = (&head) | ~(|head);
  end

  always_comb begin
    case (shift_mode_e'(shift_sel))
      SHIFT_KEEP: begin
        shifted = ext;
        pre_ovf = ~guard_ok[0];
      end
      SHIFT_UP2: begin
        shifted = ext << SH_A;
        pre_ovf = ~guard_ok[1];
      end
      SHIFT_UP4: begin
        shifted = ext << SH_B;
        pre_ovf = ~guard_ok[2];
      end
      default: begin
        shifted = $signed(ext) >>> SH_R;
        pre_ovf = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acc_rounder.sv
module acc_rounder
  import acc_scale_pkg::*;
#(
  parameter int OUT_W   = 64,
  parameter int REF_POS = 48,
  parameter int WL1     = 32,
  parameter int WL2     = 24,
  parameter int WL3     = 30,
  parameter int WL4     = 16
) (
  input  logic [OUT_W-1:0] val,
  input  logic [2:0]       round_sel,
  output logic [OUT_W-1:0] rounded
);

  localparam logic [OUT_W-1:0] ONE = {{(OUT_W-1){1'b0}}, 1'b1};

  logic [OUT_W-1:0] cand [1:4];

  for (genvar k = 1; k <= 4; k++) begin : g_rnd
    localparam int WL  = (k == 1) ? WL1 : (k == 2) ? WL2 : (k == 3) ? WL3 : WL4;
    localparam int CUT = REF_POS - WL;
    localparam logic [OUT_W-1:0] HALF = ONE << (CUT - 1);
    localparam logic [OUT_W-1:0] KEEP = ~((ONE << CUT) - ONE);
    assign cand[k] = (val + HALF) & KEEP;
  end

  always_comb begin
    case (round_mode_e'(round_sel))
      RND_W32: rounded = cand[1];
      RND_W24: rounded = cand[2];
      RND_W30: rounded = cand[3];
      RND_W16: rounded = cand[4];
      default: rounded = val;
    endcase
  end

endmodule

// File: rtl/acc_saturator.sv
module acc_saturator #(
  parameter int ACC_W  = 52,
  parameter int OUT_W  = 64,
  parameter int HEAD_W = 5
) (
  input  logic [OUT_W-1:0] rounded,
  input  logic             pre_ovf,
  input  logic             sat_en,
  output logic [OUT_W-1:0] result,
  output logic             ovf_any
);

  localparam int MAG_W = ACC_W - HEAD_W;
  localparam logic [OUT_W-1:0] POS_LIM = {{(OUT_W-MAG_W){1'b0}}, {MAG_W{1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = ~POS_LIM;

  logic [HEAD_W-1:0] head;
  logic              post_ok;

  assign head    = rounded[ACC_W-1 -: HEAD_W];
  assign post_ok = (&head) | ~(|head);
  assign ovf_any = pre_ovf | ~post_ok;

  always_comb begin
    if (sat_en && ovf_any)
      result = rounded[ACC_W-1] ? NEG_LIM : POS_LIM;
    else
      result = rounded;
  end

endmodule

// File: rtl/acc_ovf_sticky.sv
module acc_ovf_sticky (
  input  logic clk,
  input  logic rst,
  input  logic eval_stb,
  input  logic sync_pulse,
  input  logic ovf_any,
  output logic ovf_flag
);

  always_ff @(posedge clk) begin
    if (rst)
      ovf_flag <= 1'b0;
    else if (sync_pulse)
      ovf_flag <= 1'b0;
    else if (eval_stb && ovf_any)
      ovf_flag <= 1'b1;
  end

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !ovf_flag); // R10

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
    (eval_stb && ovf_any && !sync_pulse) |=> ovf_flag); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!eval_stb && !sync_pulse) |=> $stable(ovf_flag)); // R9

endmodule

// File: rtl/acc_out_scaler.sv
module acc_out_scaler #(
  parameter int ACC_W  = 52,
  parameter int OUT_W  = 64,
  parameter int HEAD_W = 5,
  parameter int SH_A   = 2,
  parameter int SH_B   = 4,
  parameter int SH_R   = 8,
  parameter int WL1    = 32,
  parameter int WL2    = 24,
  parameter int WL3    = 30,
  parameter int WL4    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [1:0]       shift_sel,
  input  logic [2:0]       round_sel,
  input  logic             sat_en,
  input  logic             eval_stb,
  input  logic             sync_pulse,
  output logic [OUT_W-1:0] result,
  output logic             ovf_flag
);

  localparam int REF_POS = ACC_W - 4;
  localparam int MAG_W   = ACC_W - HEAD_W;
  localparam logic [OUT_W-1:0] POS_LIM = {{(OUT_W-MAG_W){1'b0}}, {MAG_W{1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = ~POS_LIM;

  logic [OUT_W-1:0] shifted;
  logic [OUT_W-1:0] rounded;
  logic             pre_ovf;
  logic             ovf_any;

  acc_prescale #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .HEAD_W(HEAD_W),
    .SH_A(SH_A), .SH_B(SH_B), .SH_R(SH_R)
  ) u_prescale (
    .acc(acc_in), .shift_sel(shift_sel), .shifted(shifted), .pre_ovf(pre_ovf)
  );

  acc_rounder #(
    .OUT_W(OUT_W), .REF_POS(REF_POS),
    .WL1(WL1), .WL2(WL2), .WL3(WL3), .WL4(WL4)
  ) u_rounder (
    .val(shifted), .round_sel(round_sel), .rounded(rounded)
  );

  acc_saturator #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .HEAD_W(HEAD_W)
  ) u_sat (
    .rounded(rounded), .pre_ovf(pre_ovf), .sat_en(sat_en),
    .result(result), .ovf_any(ovf_any)
  );

  acc_ovf_sticky u_sticky (
    .clk(clk), .rst(rst), .eval_stb(eval_stb), .sync_pulse(sync_pulse),
    .ovf_any(ovf_any), .ovf_flag(ovf_flag)
  );

  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (sat_en && ovf_any) |-> (result == POS_LIM || result == NEG_LIM)); // R8

  AST_DN8_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (shift_sel == 2'd3 && (round_sel == 3'd0 || round_sel > 3'd4)) |-> !ovf_any); // R4

  AST_NO_SAT_PASS: assert property (@(posedge clk) disable iff (rst)
    !sat_en |-> (result == rounded)); // R8

endmodule

// File: tb/acc_out_scaler_tb.sv
module acc_out_scaler_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [51:0] acc_in = '0;
  logic [1:0]  shift_sel = '0;
  logic [2:0]  round_sel = '0;
  logic        sat_en = 1'b0;
  logic        eval_stb = 1'b0;
  logic        sync_pulse = 1'b0;
  logic [63:0] result;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_out_scaler u_dut (
    .clk(clk), .rst(rst), .acc_in(acc_in), .shift_sel(shift_sel),
    .round_sel(round_sel), .sat_en(sat_en), .eval_stb(eval_stb),
    .sync_pulse(sync_pulse), .result(result), .ovf_flag(ovf_flag)
  );

  localparam logic [63:0] POS = 64'h0000_7FFF_FFFF_FFFF;
  localparam logic [63:0] NEG = 64'hFFFF_8000_0000_0000;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // set data inputs at a falling edge; result is combinational
  task automatic apply(input logic [51:0] a, input logic [1:0] sh, input logic [2:0] rd,
                       input logic sat);
    @(negedge clk);
    acc_in = a; shift_sel = sh; round_sel = rd; sat_en = sat;
    #1;
  endtask

  // one clock with strobes, flag sampled at the next falling edge
  task automatic pulse(input logic ev, input logic sy);
    eval_stb = ev; sync_pulse = sy;
    @(negedge clk);
    eval_stb = 1'b0; sync_pulse = 1'b0;
  endtask

  function automatic logic [64:0] model(input logic [51:0] a, input logic [1:0] sh,
                                        input logic [2:0] rd, input logic sat);
    logic [63:0] m;
    logic ov;
    int cut;
    m = {{12{a[51]}}, a};
    ov = 1'b0;
    case (sh)
      2'd0: ov = !(a[51:47] == 5'h00 || a[51:47] == 5'h1F);
      2'd1: begin ov = !(a[51:45] == 7'h00 || a[51:45] == 7'h7F); m = m << 2; end
      2'd2: begin ov = !(a[51:43] == 9'h000 || a[51:43] == 9'h1FF); m = m << 4; end
      default: m = $signed(m) >>> 8;
    endcase
    case (rd)
      3'd1: cut = 16;
      3'd2: cut = 24;
      3'd3: cut = 18;
      3'd4: cut = 32;
      default: cut = 0;
    endcase
    if (cut != 0) m = (m + (64'd1 << (cut - 1))) & ~((64'd1 << cut) - 64'd1);
    if (!(m[51:47] == 5'h00 || m[51:47] == 5'h1F)) ov = 1'b1;
    if (sat && ov) m = m[51] ? NEG : POS;
    return {ov, m};
  endfunction

  task automatic t_reset();
    check("R11 flag after reset", {63'd0, ovf_flag}, 64'd0);
  endtask

  task automatic t_shift_modes();
    apply(52'h0_7FFF_FFFF_FFFF, 2'd0, 3'd0, 1'b0);
    check("R1 max legal no shift", result, 64'h0000_7FFF_FFFF_FFFF);
    pulse(1'b1, 1'b0);
    check("R1 no overflow at boundary", {63'd0, ovf_flag}, 64'd0);
    apply(52'h0_8000_0000_0000, 2'd0, 3'd0, 1'b0);
    check("R1 just over, unclamped", result, 64'h0000_8000_0000_0000);
    pulse(1'b1, 1'b0);
    check("R1 overflow flagged", {63'd0, ovf_flag}, 64'd1);
    pulse(1'b0, 1'b1);
    apply(52'h0_1FFF_FFFF_FFFF, 2'd1, 3'd0, 1'b0);
    check("R2 left 2 in range", result, 64'h0000_7FFF_FFFF_FFFC);
    pulse(1'b1, 1'b0);
    check("R2 no overflow at boundary", {63'd0, ovf_flag}, 64'd0);
    apply(52'h0_2000_0000_0000, 2'd1, 3'd0, 1'b0);
    check("R2 guard breach value", result, 64'h0000_8000_0000_0000);
    pulse(1'b1, 1'b0);
    check("R2 overflow flagged", {63'd0, ovf_flag}, 64'd1);
    pulse(1'b0, 1'b1);
    apply(52'hF_F800_0000_0000, 2'd2, 3'd0, 1'b0);
    check("R3 left 4 negative edge", result, 64'hFFFF_8000_0000_0000);
    pulse(1'b1, 1'b0);
    check("R3 no overflow at boundary", {63'd0, ovf_flag}, 64'd0);
    apply(52'hF_F000_0000_0000, 2'd2, 3'd0, 1'b1);
    check("R3 breach clamps negative", result, NEG);
    pulse(1'b1, 1'b0);
    check("R3 overflow flagged", {63'd0, ovf_flag}, 64'd1);
    pulse(1'b0, 1'b1);
    apply(52'h7_FFFF_FFFF_FFFF, 2'd3, 3'd0, 1'b1);
    check("R4 right 8 positive", result, 64'h0000_07FF_FFFF_FFFF);
    apply(52'h8_0000_0000_0000, 2'd3, 3'd0, 1'b1);
    check("R4 right 8 negative", result, 64'hFFFF_F800_0000_0000);
    pulse(1'b1, 1'b0);
    check("R4 no pre-check", {63'd0, ovf_flag}, 64'd0);
  endtask

  task automatic t_round_modes();
    apply(52'h0_0000_0000_7FFF, 2'd0, 3'd1, 1'b0);
    check("R6 sel1 below half", result, 64'd0);
    apply(52'h0_0000_0000_8000, 2'd0, 3'd1, 1'b0);
    check("R6 sel1 at half", result, 64'h1_0000);
    apply(52'hF_FFFF_FFFF_8000, 2'd0, 3'd1, 1'b0);
    check("R6 sel1 negative half", result, 64'd0);
    apply(52'hF_FFFF_FFFF_7FFF, 2'd0, 3'd1, 1'b0);
    check("R6 sel1 negative below half", result, 64'hFFFF_FFFF_FFFF_0000);
    apply(52'h0_0000_0080_0000, 2'd0, 3'd2, 1'b0);
    check("R6 sel2 at half", result, 64'h100_0000);
    apply(52'h0_0000_0001_FFFF, 2'd0, 3'd3, 1'b0);
    check("R6 sel3 below half", result, 64'd0);
    apply(52'h0_0000_0002_0000, 2'd0, 3'd3, 1'b0);
    check("R6 sel3 at half", result, 64'h4_0000);
    apply(52'h0_0000_8000_0000, 2'd0, 3'd4, 1'b0);
    check("R6 sel4 at half", result, 64'h1_0000_0000);
    apply(52'h0_0000_7FFF_FFFF, 2'd0, 3'd4, 1'b0);
    check("R6 sel4 below half", result, 64'd0);
    for (int r = 0; r < 8; r++) begin
      if (r == 0 || r > 4) begin
        apply(52'h0_1234_5678_9ABC, 2'd0, 3'(r), 1'b0);
        check("R5 pass-through round select", result, 64'h0000_1234_5678_9ABC);
      end
    end
  endtask

  task automatic t_post_round();
    pulse(1'b0, 1'b1);
    apply(52'h0_7FFF_FFFF_FFFF, 2'd0, 3'd1, 1'b0);
    check("R7 round carries into guard", result, 64'h0000_8000_0000_0000);
    pulse(1'b1, 1'b0);
    check("R7 post-round overflow flagged", {63'd0, ovf_flag}, 64'd1);
    apply(52'h0_7FFF_8000_0000, 2'd0, 3'd4, 1'b1);
    check("R7 post-round clamps", result, POS);
  endtask

  task automatic t_saturate();
    apply(52'h4_0000_0000_0000, 2'd0, 3'd0, 1'b1);
    check("R8 positive clamp", result, POS);
    apply(52'h8_0000_0000_0000, 2'd0, 3'd0, 1'b1);
    check("R8 negative clamp", result, NEG);
    apply(52'h4_0000_0000_0000, 2'd1, 3'd0, 1'b1);
    check("R8 clamp keyed on bit 51", result, POS);
    apply(52'h4_0000_0000_0000, 2'd1, 3'd0, 1'b0);
    check("R8 disabled leaves value", result, 64'h0010_0000_0000_0000);
  endtask

  task automatic t_sticky();
    pulse(1'b0, 1'b1);
    check("R10 sync clears", {63'd0, ovf_flag}, 64'd0);
    apply(52'h8_0000_0000_0000, 2'd0, 3'd0, 1'b0);
    pulse(1'b0, 1'b0);
    pulse(1'b0, 1'b0);
    check("R9 overflow ignored without strobe", {63'd0, ovf_flag}, 64'd0);
    pulse(1'b1, 1'b0);
    check("R9 strobed overflow sets", {63'd0, ovf_flag}, 64'd1);
    apply(52'h0_0000_0000_0001, 2'd0, 3'd0, 1'b0);
    pulse(1'b1, 1'b0);
    check("R9 clean evaluation keeps flag", {63'd0, ovf_flag}, 64'd1);
    apply(52'h8_0000_0000_0000, 2'd0, 3'd0, 1'b0);
    pulse(1'b1, 1'b1);
    check("R10 sync beats same-cycle overflow", {63'd0, ovf_flag}, 64'd0);
  endtask

  task automatic t_sweep();
    logic [51:0] lfsr;
    logic [64:0] exp;
    lfsr = 52'hA_5C3E_9127_0B4D;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[50:0], lfsr[51] ^ lfsr[48]};
      // shape the value: narrow some samples so both in-range and overflow occur
      apply((i % 3 == 0) ? {{8{lfsr[51]}}, lfsr[43:0]} : lfsr,
            2'(i), 3'(i / 4), 1'(i / 2));
      exp = model(acc_in, shift_sel, round_sel, sat_en);
      check("R1 R2 R3 R4 R5 R6 R7 R8 sweep", result, exp[63:0]);
      pulse(1'b0, 1'b1);
      pulse(1'b1, 1'b0);
      check("R9 sweep flag", {63'd0, ovf_flag}, {63'd0, exp[64]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_shift_modes();
    t_round_modes();
    t_post_round();
    t_saturate();
    t_sticky();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule